// File: doc/BRIEF.md
# Completion Event Ring Producer

This block turns a stream of transfer completions into fixed-size 16-byte event records placed in a circular ring in memory. Each accepted completion carries a 4-bit status code and a 4-bit error detail. The block formats them into a 128-bit record and issues one record write at the current byte offset. It then advances its write offset, wrapping it at the programmed ring length in bytes. Records leave in exactly the order the completions arrive, so a consumer can pair the Nth record with the Nth descriptor it issued.

The consumer reports its progress by writing its read offset through a doorbell. The producer compares its next write offset against that read offset. When one more record would make the two equal, the ring counts as full. The block then raises a stall output and refuses further completions until the doorbell frees space. Each record write comes with a one-cycle end-of-block interrupt request whenever unread records remain after the write.

Top module: `evt_ring_producer`

## Requirements
- R1: A record carries the status code in bits 31:28 and the error detail in bits 27:24 of its first 32-bit word. Every other bit of the 128-bit record is zero. Status 1 denotes success and status 4 denotes error; both pass through unchanged.
- R2: A completion accepted at a clock edge produces `rec_we` high for exactly the following cycle. `rec_offset` then equals the write offset before the edge, and `wr_offset` has advanced by 16 in that same cycle.
- R3: When the advanced offset is at or above `ring_len`, `ring_len` is subtracted from it. The offset therefore wraps to 0 at the ring end, including for ring lengths that are not a power of two.
- R4: `ring_full` is high exactly when the advanced write offset would equal the read offset. A completion strobe presented while `ring_full` is high is ignored: no record, no offset change.
- R5: A doorbell whose value is a multiple of 16 and below `ring_len` becomes the read offset at that edge.
- R6: A doorbell value that is not a multiple of 16, or that is at or above `ring_len`, is ignored and leaves the read offset unchanged.
- R7: `eob_irq` pulses for one cycle together with a record write, whenever the write and read offsets differ after that write.
- R8: Reset sets both offsets to 0 and holds `rec_we`, `eob_irq` and `ring_full` low.
- R9: Records are written in the order of the accepted completions, at consecutive 16-byte offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion strobe |
| cmp_code | input | 4 | Completion status code |
| cmp_info | input | 4 | Completion error detail |
| ring_len | input | 16 | Ring length in bytes (multiple of 16) |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | 16 | Consumer read offset in bytes |
| ring_full | output | 1 | Back-pressure: ring has no free record |
| rec_we | output | 1 | Record write strobe |
| rec_offset | output | 16 | Byte offset of the record being written |
| rec_data | output | 128 | Record contents |
| wr_offset | output | 16 | Current producer write offset in bytes |
| eob_irq | output | 1 | End-of-block interrupt request pulse |

## Verification
The record write, its offset, the advanced `wr_offset` and the interrupt pulse all come from registers. They are due in the cycle after the edge that accepts the strobe. A doorbell takes effect on the read offset at its own edge. `ring_full` is combinational from both offsets, so it reflects a doorbell or a write in the cycle after that edge. The bench drives every stimulus on a falling edge and lets exactly one rising edge pass. It then checks every output on the next falling edge, which is the single cycle in which each result is due. The one-cycle pulses are checked again one cycle later to confirm they have dropped.

// File: rtl/erp_pkg.sv
package erp_pkg;

   localparam int unsigned REC_BYTES = 16;
   localparam int unsigned FLD_W     = 4;

   typedef enum logic [FLD_W-1:0] {
      CMP_OK  = 4'd1,
      CMP_ERR = 4'd4
   } cmp_status_e;

   typedef struct packed {
      logic [FLD_W-1:0] code;
      logic [FLD_W-1:0] info;
   } cmp_t;

endpackage

// File: rtl/erp_ofs_step.sv
module erp_ofs_step #(
   parameter int unsigned OFS_W = 16,
   parameter int unsigned STEP  = 16
) (
   input  logic [OFS_W-1:0] cur,
   input  logic [OFS_W-1:0] len,
   output logic [OFS_W-1:0] nxt
);
   localparam int unsigned SUM_W = OFS_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] wrapped;

   always_comb begin
      sum     = {1'b0, cur} + SUM_W'(STEP);
      wrapped = sum - {1'b0, len};
      nxt     = (sum >= {1'b0, len}) ? wrapped[OFS_W-1:0] : sum[OFS_W-1:0];
   end
endmodule

// File: rtl/erp_rec_pack.sv
module erp_rec_pack
   import erp_pkg::*;
#(
   parameter int unsigned REC_W  = 128,
   parameter int unsigned WORD_W = 32
) (
   input  cmp_t             cmp,
   output logic [REC_W-1:0] rec
);
   localparam int unsigned N_WORDS = REC_W / WORD_W;
   localparam int unsigned LOW_W   = WORD_W - 2 * FLD_W;

   if (REC_W % WORD_W != 0) begin : g_bad_word
      $error("record width must be whole words");
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      if (w == 0) begin : g_head
         assign rec[WORD_W-1:0] = {cmp.code, cmp.info, {LOW_W{1'b0}}};
      end else begin : g_zero
         assign rec[w*WORD_W +: WORD_W] = '0;
      end
   end
endmodule

// File: rtl/erp_db_track.sv
module erp_db_track #(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned ALIGN_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             db_valid,
   input  logic [OFS_W-1:0] db_offset,
   input  logic [OFS_W-1:0] ring_len,
   output logic [OFS_W-1:0] rd_q,
   output logic [OFS_W-1:0] rd_d
);
   logic db_ok;

   always_comb begin
      db_ok = db_valid && (db_offset[ALIGN_LOG-1:0] == '0) && (db_offset < ring_len);
      rd_d  = db_ok ? db_offset : rd_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
   end

   // R6
   db_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_valid && db_offset[ALIGN_LOG-1:0] != '0) |=> $stable(rd_q));

   // R5
   db_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q[ALIGN_LOG-1:0] == '0);
endmodule

// File: rtl/evt_ring_producer.sv
module evt_ring_producer
   import erp_pkg::*;
#(
   parameter int unsigned OFS_W = 16,
   parameter int unsigned REC_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_valid,
   input  logic [3:0]       cmp_code,
   input  logic [3:0]       cmp_info,
   input  logic [OFS_W-1:0] ring_len,
   input  logic             db_valid,
   input  logic [OFS_W-1:0] db_offset,
   output logic             ring_full,
   output logic             rec_we,
   output logic [OFS_W-1:0] rec_offset,
   output logic [REC_W-1:0] rec_data,
   output logic [OFS_W-1:0] wr_offset,
   output logic             eob_irq
);
   localparam int unsigned ALIGN_LOG = $clog2(REC_BYTES);

   if (REC_W != REC_BYTES * 8) begin : g_bad_rec
      $error("record width must match the record size");
   end
   if (OFS_W <= ALIGN_LOG) begin : g_bad_ofs
      $error("offset width too small");
   end

   logic [OFS_W-1:0] wr_q, wr_nxt, rd_q, rd_d;
   logic [REC_W-1:0] rec_fmt;
   logic             accept;
   cmp_t             cmp;

   assign cmp = '{code: cmp_code, info: cmp_info};

   erp_ofs_step #(.OFS_W(OFS_W), .STEP(REC_BYTES)) u_step (
      .cur(wr_q), .len(ring_len), .nxt(wr_nxt));

   erp_rec_pack #(.REC_W(REC_W)) u_pack (.cmp(cmp), .rec(rec_fmt));

   erp_db_track #(.OFS_W(OFS_W), .ALIGN_LOG(ALIGN_LOG)) u_db (
      .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_offset(db_offset),
      .ring_len(ring_len), .rd_q(rd_q), .rd_d(rd_d));

   always_comb begin
      ring_full = (wr_nxt == rd_q);
      accept    = cmp_valid && !ring_full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q       <= '0;
         rec_we     <= 1'b0;
         rec_offset <= '0;
         rec_data   <= '0;
         eob_irq    <= 1'b0;
      end else begin
         rec_we  <= accept;
         eob_irq <= accept && (wr_nxt != rd_d);
         if (accept) begin
            wr_q       <= wr_nxt;
            rec_offset <= wr_q;
            rec_data   <= rec_fmt;
         end
      end
   end

   assign wr_offset = wr_q;

   // R4
   stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && ring_full) |=> (!rec_we && $stable(wr_offset)));

   // R2
   rec_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !ring_full) |=> (rec_we && rec_offset == $past(wr_offset)));

   // R7
   eob_with_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eob_irq |-> rec_we);

   // R3
   wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_offset[ALIGN_LOG-1:0] == '0);

   // R1
   rec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_we |-> (rec_data[REC_W-1:32] == '0 && rec_data[23:0] == '0));
endmodule

// File: tb/evt_ring_producer_tb_top.sv
module evt_ring_producer_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         cmp_valid;
   logic [3:0]   cmp_code, cmp_info;
   logic [15:0]  ring_len;
   logic         db_valid;
   logic [15:0]  db_offset;
   logic         ring_full, rec_we, eob_irq;
   logic [15:0]  rec_offset, wr_offset;
   logic [127:0] rec_data;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   evt_ring_producer dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
      .cmp_info(cmp_info), .ring_len(ring_len), .db_valid(db_valid),
      .db_offset(db_offset), .ring_full(ring_full), .rec_we(rec_we),
      .rec_offset(rec_offset), .rec_data(rec_data), .wr_offset(wr_offset),
      .eob_irq(eob_irq));

   // op[3:0] arg[15:0] exp_off[15:0] exp_wr[15:0] exp_full[3:0]; op 0 = completion, 1 = doorbell
   localparam logic [55:0] VEC [6] = '{
      {4'd0, 16'h0010, 16'd0,  16'd16, 4'd0},
      {4'd0, 16'h0043, 16'd16, 16'd32, 4'd0},
      {4'd0, 16'h001F, 16'd32, 16'd48, 4'd1},
      {4'd1, 16'd32,   16'd0,  16'd48, 4'd0},
      {4'd0, 16'h0040, 16'd48, 16'd0,  4'd0},
      {4'd0, 16'h0015, 16'd0,  16'd16, 4'd1}
   };

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] rec_of(input logic [3:0] c, input logic [3:0] i);
      return {96'b0, c, i, 24'b0};
   endfunction

   task automatic complete(input logic [3:0] c, input logic [3:0] i);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_code = c; cmp_info = i;
      @(negedge clk);
      cmp_valid = 1'b0;
   endtask

   task automatic ring_db(input logic [15:0] v);
      @(negedge clk);
      db_valid = 1'b1; db_offset = v;
      @(negedge clk);
      db_valid = 1'b0;
   endtask

   task automatic run_all();
      rst_n = 1'b0; cmp_valid = 1'b0; cmp_code = '0; cmp_info = '0;
      db_valid = 1'b0; db_offset = '0; ring_len = 16'd64;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 wr_offset after reset", wr_offset, 0);
      chk("R8 rec_we after reset", rec_we, 0);
      chk("R8 eob_irq after reset", eob_irq, 0);
      chk("R8 ring_full after reset", ring_full, 0);

      // R9 R1 R2 R3 R4 R5 walk through the vector table
      for (int k = 0; k < 6; k++) begin
         logic [55:0] v;
         v = VEC[k];
         if (v[55:52] == 4'd0) begin
            complete(v[43:40], v[39:36]);
            chk("R2 rec_we", rec_we, 1);
            chk("R9 rec_offset", rec_offset, v[35:20]);
            chk("R1 rec_data", rec_data, rec_of(v[43:40], v[39:36]));
            chk("R7 eob_irq", eob_irq, 1);
         end else begin
            ring_db(v[51:36]);
            chk("R5 no write on doorbell", rec_we, 0);
         end
         chk("R3 wr_offset", wr_offset, v[19:4]);
         chk("R4 ring_full", ring_full, v[3:0]);
      end

      // R7 pulse lasts one cycle
      @(negedge clk);
      chk("R7 eob_irq drops", eob_irq, 0);
      chk("R2 rec_we drops", rec_we, 0);

      // R4 strobe while full is ignored (wr=16, rd=32)
      complete(4'd1, 4'd2);
      chk("R4 no write while full", rec_we, 0);
      chk("R4 wr_offset held while full", wr_offset, 16);

      // R6 unaligned and out-of-range doorbells ignored
      ring_db(16'd24);
      chk("R6 unaligned doorbell ignored", ring_full, 1);
      ring_db(16'd64);
      chk("R6 out-of-range doorbell ignored", ring_full, 1);

      // R5 valid doorbell frees space
      ring_db(16'd0);
      chk("R5 doorbell frees ring", ring_full, 0);

      // R8 reset again, then a 48-byte ring for non-power-of-two wrap
      @(negedge clk);
      rst_n = 1'b0; ring_len = 16'd48;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R8 wr_offset cleared", wr_offset, 0);
      complete(4'd4, 4'd9);
      complete(4'd1, 4'd0);
      chk("R4 full on 48-byte ring", ring_full, 1);
      ring_db(16'd16);
      complete(4'd4, 4'd7);
      chk("R3 rec_offset before wrap", rec_offset, 32);
      chk("R3 wrap at 48", wr_offset, 0);
      chk("R1 error record", rec_data, rec_of(4'd4, 4'd7));
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            errors++; checks++;
            $display("FAIL R8 watchdog expired actual=hang expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule